// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a real-time counter peripheral that sits on a simple 32-bit register bus. The bus has a byte address, read and write strobes and separate write and read data. A 32-bit seconds count advances by one in every clock cycle where the one-per-second tick enable is high. A prescaler outside the block produces that tick from the system clock. The counter cannot be stopped. Software sets the time by writing a new value over the count.

Software also programs a 32-bit match value. When the count and the match value become equal, a sticky alarm status bit is set. That status bit, gated by a one-bit mask, drives a level-sensitive interrupt line. Any write to the clear register drops the status bit. The top of the 4 KB register window returns fixed identification bytes, one byte per word.

Top module: `sec_alarm_ctr`

## Requirements
- R1: After a synchronous reset the count, match value, load readback, mask bit and raw status are all zero, and `irq` is low.
- R2: The count at word offset 0x00 rises by one after each clock edge where `tick_en` is high. It wraps from 0xFFFFFFFF to 0. With no tick and no load, the count holds.
- R3: A write to offset 0x08 makes the count equal the written value after that edge, even when `tick_en` is high in the same cycle. Reads of 0x08 return the last value written there.
- R4: A write to offset 0x04 stores the 32-bit match value, and reads of 0x04 return it.
- R5: Reads of offset 0x0C always return 1. Writes to 0x0C change no state.
- R6: A write to offset 0x10 keeps only data bit 0 as the mask bit. Reads of 0x10 return that bit in bit 0 and zeros above it.
- R7: Reads of offset 0x18 return the raw status ANDed with the mask bit. `irq` equals that value.
- R8: Raw status bit 0 (offset 0x14) is set on the same edge where a tick, a load write or a match write leaves the count exactly equal to the match value, modulo 2^32. Equality that persists with no such event does not set it again.
- R9: The raw status stays set until it is cleared, even after the count moves past the match value. If an alarm event and a clear write fall in the same cycle, the status ends up set.
- R10: Any write to offset 0x1C clears the raw status, whatever the data value, including zero.
- R11: Writes to 0x00, 0x14, 0x18 and to unmapped offsets change no state. Reads of 0x1C and of unmapped offsets return 0.
- R12: Reads of word offsets 0xFE0 through 0xFFC return, in bits 7:0, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order. `bus_rdata` is combinational from the address and is 0 while `bus_rd` is low. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Level interrupt, masked alarm status |

## Verification
The checker assumes that a write is a single-cycle strobe and that the address is stable while the strobe is high. It also assumes that `tick_en` is a plain one-cycle enable. No alarm property makes any assumption about how often ticks arrive. The bench drives every strobe and tick away from the rising edge, and it keeps each write to exactly one cycle. It raises a tick together with a write only where a requirement is about that collision: load priority and set-over-clear.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [3:0] {
        SEL_COUNT,
        SEL_MATCH,
        SEL_LOAD,
        SEL_CTRL,
        SEL_MASK,
        SEL_RAW,
        SEL_MSKST,
        SEL_CLEAR,
        SEL_ID,
        SEL_NONE
    } sel_e;

    localparam int ID_WORDS = 8;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [2:0]        id_idx
);
    localparam int IDX_W   = ADDR_W - 2;
    localparam int ID_BASE = (1 << IDX_W) - ID_WORDS;

    logic [IDX_W-1:0] word_idx;

    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        id_idx   = word_idx[2:0];
        if (int'(word_idx) >= ID_BASE) begin
            sel = SEL_ID;
        end else begin
            case (int'(word_idx))
                0:       sel = SEL_COUNT;
                1:       sel = SEL_MATCH;
                2:       sel = SEL_LOAD;
                3:       sel = SEL_CTRL;
                4:       sel = SEL_MASK;
                5:       sel = SEL_RAW;
                6:       sel = SEL_MSKST;
                7:       sel = SEL_CLEAR;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sac_counter.sv
module sac_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_nx,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] load_q
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] load;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_we) begin
            st_d.count = wdata;
            st_d.load  = wdata;
        end else if (tick_en) begin
            st_d.count = st_q.count + DATA_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count_nx = st_d.count;
    assign count_q  = st_q.count;
    assign load_q   = st_q.load;
endmodule

// File: rtl/sac_alarm.sv
module sac_alarm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              load_we,
    input  logic              match_we,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count_nx,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw_q,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] match;
        logic              mask;
        logic              raw;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic    evt;
    logic    hit;

    always_comb begin
        st_d = st_q;
        if (match_we) st_d.match = wdata;
        if (mask_we)  st_d.mask  = wdata[0];
        evt = tick_en | load_we | match_we;
        hit = evt && (count_nx == st_d.match);
        if (hit)         st_d.raw = 1'b1;
        else if (clr_we) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign match_q = st_q.match;
    assign mask_q  = st_q.mask;
    assign raw_q   = st_q.raw;
    assign irq     = st_q.raw & st_q.mask;
endmodule

// File: rtl/sec_alarm_ctr.sv
module sec_alarm_ctr
    import sac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    sel_e              sel;
    logic [2:0]        id_idx;
    logic [DATA_W-1:0] count_nx, count_q, load_q, match_q;
    logic              mask_q, raw_q;
    logic              load_we, match_we, mask_we, clr_we;

    sac_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    assign load_we  = bus_wr && (sel == SEL_LOAD);
    assign match_we = bus_wr && (sel == SEL_MATCH);
    assign mask_we  = bus_wr && (sel == SEL_MASK);
    assign clr_we   = bus_wr && (sel == SEL_CLEAR);

    sac_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_we  (load_we),
        .wdata    (bus_wdata),
        .count_nx (count_nx),
        .count_q  (count_q),
        .load_q   (load_q)
    );

    sac_alarm #(.DATA_W(DATA_W)) u_alm (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load_we  (load_we),
        .match_we (match_we),
        .mask_we  (mask_we),
        .clr_we   (clr_we),
        .wdata    (bus_wdata),
        .count_nx (count_nx),
        .match_q  (match_q),
        .mask_q   (mask_q),
        .raw_q    (raw_q),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_COUNT: bus_rdata = count_q;
                SEL_MATCH: bus_rdata = match_q;
                SEL_LOAD:  bus_rdata = load_q;
                SEL_CTRL:  bus_rdata = DATA_W'(1);
                SEL_MASK:  bus_rdata = DATA_W'(mask_q);
                SEL_RAW:   bus_rdata = DATA_W'(raw_q);
                SEL_MSKST: bus_rdata = DATA_W'(raw_q & mask_q);
                SEL_ID:    bus_rdata = DATA_W'(id_byte(id_idx));
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] count_q,
    input logic              mask_q,
    input logic              raw_q
);
    logic [ADDR_W-3:0] widx;
    logic              wr_load, wr_mask, wr_clr;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign wr_load = bus_wr && (int'(widx) == 2);
    assign wr_mask = bus_wr && (int'(widx) == 4);
    assign wr_clr  = bus_wr && (int'(widx) == 7);

    p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_load) |=> (count_q == $past(count_q) + DATA_W'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_load) |=> $stable(count_q));

    p_load_wins_r3: assert property (@(posedge clk) disable iff (rst)
        wr_load |=> (count_q == $past(bus_wdata)));

    p_ctrl_one_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(widx) == 3) |-> (bus_rdata == DATA_W'(1)));

    p_mask_bit_r6: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (mask_q == $past(bus_wdata[0])));

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q && raw_q));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !wr_clr) |=> raw_q);

    p_clear_any_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !tick_en) |=> !raw_q);
endmodule

bind sec_alarm_ctr sac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count_q   (count_q),
    .mask_q    (mask_q),
    .raw_q     (raw_q)
);

// File: tb/tb_sec_alarm_ctr.sv
module tb_sec_alarm_ctr;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_alarm_ctr #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_id(input int i);
        logic [7:0] t [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        return t[i];
    endfunction

    function automatic logic [DW-1:0] exp_reset(input int w);
        if (w >= 1016) return DW'(exp_id(w - 1016));
        if (w == 3)    return DW'(1);
        return '0;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 R5 R11 R12: full sweep of all word offsets after reset
        chk("R1 irq", DW'(irq), '0);
        for (int w = 0; w < 1024; w++) begin
            if (w >= 1016)   rd_chk("R12 id", AW'(w << 2), exp_reset(w));
            else if (w == 3) rd_chk("R5 ctrl", AW'(w << 2), exp_reset(w));
            else if (w < 8)  rd_chk("R1 reset", AW'(w << 2), exp_reset(w));
            else             rd_chk("R11 unmapped", AW'(w << 2), exp_reset(w));
        end
        rd_chk("R12 low bits", 12'hFE7, 32'h10);

        // R4 match readback, R3 load
        wr(12'h004, 32'hDEADBEEF);
        rd_chk("R4 match", 12'h004, 32'hDEADBEEF);
        wr(12'h008, 32'h1000);
        rd_chk("R3 count", 12'h000, 32'h1000);
        rd_chk("R3 load rb", 12'h008, 32'h1000);

        // R2 ticking, hold, wrap
        ticks(5);
        rd_chk("R2 count", 12'h000, 32'h1005);
        repeat (3) @(negedge clk);
        rd_chk("R2 hold", 12'h000, 32'h1005);
        wr(12'h008, 32'hFFFFFFFE);
        ticks(2);
        rd_chk("R2 wrap", 12'h000, 32'h0);

        // R3 load beats same-cycle tick
        @(negedge clk);
        bus_addr = 12'h008; bus_wdata = 32'd100; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd_chk("R3 priority", 12'h000, 32'd100);

        // R11 ignored writes
        wr(12'h000, 32'h55);
        wr(12'h014, 32'hFFFFFFFF);
        wr(12'h018, 32'hFFFFFFFF);
        wr(12'h020, 32'hFFFFFFFF);
        wr(12'hFE0, 32'hFFFFFFFF);
        rd_chk("R11 count kept", 12'h000, 32'd100);
        rd_chk("R11 raw kept", 12'h014, 32'h0);
        rd_chk("R11 id kept", 12'hFE0, 32'h31);
        rd_chk("R11 match kept", 12'h004, 32'hDEADBEEF);

        // R5 control write ignored
        wr(12'h00C, 32'h0);
        rd_chk("R5 ctrl", 12'h00C, 32'h1);
        rd_chk("R5 count kept", 12'h000, 32'd100);

        // R6 mask bit 0 only
        wr(12'h010, 32'hFFFFFFFE);
        rd_chk("R6 mask", 12'h010, 32'h0);
        wr(12'h010, 32'h3);
        rd_chk("R6 mask", 12'h010, 32'h1);
        wr(12'h010, 32'h0);

        // R8 alarm via ticks, R7 masking
        wr(12'h008, 32'd10);
        wr(12'h004, 32'd13);
        ticks(2);
        rd_chk("R8 before", 12'h014, 32'h0);
        ticks(1);
        rd_chk("R8 hit", 12'h014, 32'h1);
        rd_chk("R7 masked off", 12'h018, 32'h0);
        chk("R7 irq off", DW'(irq), '0);
        wr(12'h010, 32'h1);
        rd_chk("R7 masked on", 12'h018, 32'h1);
        chk("R7 irq on", DW'(irq), 32'h1);

        // R9 sticky past match
        ticks(2);
        rd_chk("R9 sticky", 12'h014, 32'h1);
        rd_chk("R9 count", 12'h000, 32'd15);

        // R10 clear with zero data
        wr(12'h01C, 32'h0);
        rd_chk("R10 raw", 12'h014, 32'h0);
        chk("R10 irq", DW'(irq), '0);

        // R8 immediate on match write, no re-fire while merely equal
        wr(12'h004, 32'd15);
        rd_chk("R8 match wr", 12'h014, 32'h1);
        wr(12'h01C, 32'hFFFFFFFF);
        repeat (3) @(negedge clk);
        rd_chk("R8 no refire", 12'h014, 32'h0);

        // R8 immediate on load write
        wr(12'h004, 32'd500);
        rd_chk("R8 no hit", 12'h014, 32'h0);
        wr(12'h008, 32'd500);
        rd_chk("R8 load wr", 12'h014, 32'h1);
        chk("R7 irq", DW'(irq), 32'h1);
        wr(12'h01C, 32'h0);

        // R8 across wrap
        wr(12'h004, 32'h0);
        wr(12'h008, 32'hFFFFFFFF);
        rd_chk("R8 pre wrap", 12'h014, 32'h0);
        ticks(1);
        rd_chk("R8 wrap hit", 12'h014, 32'h1);
        wr(12'h01C, 32'h0);

        // R9 set wins over same-cycle clear
        wr(12'h004, 32'h1);
        wr(12'h01C, 32'h0);
        rd_chk("R9 pre", 12'h014, 32'h0);
        @(negedge clk);
        bus_addr = 12'h01C; bus_wdata = 32'h0; bus_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        rd_chk("R9 set wins", 12'h014, 32'h1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule